// File: doc/BRIEF.md
# Chainable Two-Channel 16-bit Timer with Coherent Capture

This block holds two 16-bit up/down counters, a lower half and an upper half, that can work alone or be chained into one 32-bit counter. The lower half advances on an enable taken from a free-running prescaler, or it follows a two-phase quadrature encoder. The upper half either counts its own prescaled enable or, when chaining is selected, steps once for every wrap of the lower half. A wrap from all ones to zero moves it up by one. A wrap from zero to all ones moves it down by one. A quadrature-driven pair therefore tracks a signed 32-bit position.

Each half has a capture register that loads the count on a rising edge of its own capture pin. When both pins rise together, the two registers hold one coherent 32-bit value. This holds even when the lower half wraps in the capture cycle. Software configures the block through a small write port and reads the counts and captures directly from output ports.

Top module: `ctmr_top`

## Requirements
- R1: After reset, both counters and both capture registers read zero. Both start bits, both clock-select fields and the phase-mode bit are zero.
- R2: A write with `wr_en` high updates one register, selected by `wr_addr`:
  - address 0 (lower control): bits [3:0] are the lower clock select and bit 4 is the phase-mode bit.
  - address 1 (upper control): bits [3:0] are the upper clock select.
  - address 2 (start): bit 0 starts the lower half and bit 1 starts the upper half.
  - address 3: presets the lower count.
  - address 4: presets the upper count.
  A preset takes priority over counting in the same cycle.
- R3: When the phase-mode bit is clear, the lower half counts in the following way:
  - clock-select codes 0, 1, 2 and 3 give one count per 1, 4, 16 and 64 clocks.
  - any window of 10·4^code consecutive enabled cycles adds exactly 10.
  - every other code holds the count.
- R4: A half whose start bit is clear holds its count.
- R5: With upper clock select 4'b1111 and both start bits set, a lower wrap from 16'hFFFF to 16'h0000 adds one to the upper count. For example, 16'h03A1 becomes 16'h03A2.
- R6: With upper clock select 4'b1111, phase mode set and both halves started, a lower wrap from 16'h0000 to 16'hFFFF subtracts one from the upper count.
- R7: With upper clock select 4'b1111 and the upper start bit clear, lower wraps are dropped and the upper count does not change.
- R8: In phase mode, the encoder state is written {A,B}.
  - Each single-bit change along the sequence 00→10→11→01→00 adds one to the lower count.
  - Each single-bit change in the reverse direction subtracts one.
  - The count changes within six clocks of the pin change.
- R9: A change of both encoder phases in the same sampled step leaves the count unchanged.
- R10: A rising edge on a capture pin loads that half's capture register with the count held just before the third rising clock edge after the pin goes high. The other half's capture register is unchanged.
- R11: When both capture pins rise together, {upper capture, lower capture} equals one value that the 32-bit count actually held. This includes the cycle in which the lower half wraps.
- R12: With an upper clock select of 0 to 3, the upper half counts its own prescaled enable at the same rates as in R3, independent of the lower half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 16 | Write data |
| cap_lo_pin | input | 1 | Lower-half capture pin, asynchronous |
| cap_hi_pin | input | 1 | Upper-half capture pin, asynchronous |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| cnt_lo | output | 16 | Lower count |
| cnt_hi | output | 16 | Upper count |
| cap_lo | output | 16 | Lower capture register |
| cap_hi | output | 16 | Upper capture register |

## Verification
Each prescaler code is run over a window whose length is a multiple of its division. This separates the four rates from one another and from the held codes.

Chained counting is tried with lower presets a few steps below 16'hFFFF, with and without the upper start bit. This distinguishes a carry that is taken from one that is dropped.

The encoder is walked one step at a time upward across the top wrap and then downward across zero, and the bench checks the signed 32-bit position after every step. A double-phase jump is inserted to show that it is ignored.

Paired captures are swept across the wrap cycle, so a snapshot taken after the update, or a torn snapshot, differs from the expected value. A single-pin capture then shows that the other half's register does not move.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
    localparam int CSEL_W = 4;
    localparam logic [CSEL_W-1:0] CSEL_CHAIN = 4'hF;

    typedef enum logic [2:0] {
        A_CTL_LO = 3'd0,
        A_CTL_HI = 3'd1,
        A_RUN    = 3'd2,
        A_CNT_LO = 3'd3,
        A_CNT_HI = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/ctmr_sync.sv
module ctmr_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/ctmr_quad.sv
module ctmr_quad (
    input  logic clk,
    input  logic rst_n,
    input  logic ph_a,
    input  logic ph_b,
    output logic step_up,
    output logic step_dn
);
    typedef struct packed {
        logic [1:0] prev;
    } quad_st_t;

    quad_st_t st_d, st_q;
    logic [1:0] now_ab;
    logic [1:0] moved;
    logic       single;
    logic       fwd;

    always_comb begin
        now_ab  = {ph_a, ph_b};
        moved   = now_ab ^ st_q.prev;
        single  = moved[1] ^ moved[0];
        // Forward when the new A differs from the old B
        fwd     = ph_a ^ st_q.prev[0];
        step_up = single & fwd;
        step_dn = single & ~fwd;
        st_d      = st_q;
        st_d.prev = now_ab;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_double_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (({ph_a, ph_b} ^ st_q.prev) == 2'b11) |-> !(step_up || step_dn));
endmodule

// File: rtl/ctmr_chan.sv
module ctmr_chan #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         cap_edge,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cap,
    output logic         carry,
    output logic         borrow
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] cap;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        carry  = 1'b0;
        borrow = 1'b0;
        if (ld) begin
            st_d.cnt = ld_val;
        end else if (inc) begin
            st_d.cnt = st_q.cnt + 1'b1;
            carry    = &st_q.cnt;
        end else if (dec) begin
            st_d.cnt = st_q.cnt - 1'b1;
            borrow   = ~|st_q.cnt;
        end
        // Capture takes the value from before this cycle's update
        if (cap_edge) st_d.cap = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign cap = st_q.cap;

    p_capture_pre_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_edge |=> (cap == $past(cnt)));
endmodule

// File: rtl/ctmr_top.sv
module ctmr_top #(
    parameter int CNT_W     = 16,
    parameter int DIV_CODES = 4,
    parameter int DIV_LOG2  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             cap_lo_pin,
    input  logic             cap_hi_pin,
    input  logic             enc_a,
    input  logic             enc_b,
    output logic [CNT_W-1:0] cnt_lo,
    output logic [CNT_W-1:0] cnt_hi,
    output logic [CNT_W-1:0] cap_lo,
    output logic [CNT_W-1:0] cap_hi
);
    import ctmr_pkg::*;

    localparam int PS_W = DIV_LOG2 * (DIV_CODES - 1);

    typedef struct packed {
        logic [CSEL_W-1:0] csel_lo;
        logic              phase_lo;
        logic [CSEL_W-1:0] csel_hi;
        logic              run_lo;
        logic              run_hi;
        logic [PS_W-1:0]   ps;
        logic [1:0]        cap_prev;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [DIV_CODES-1:0] tick;
    logic [1:0]           cap_sync;
    logic [1:0]           enc_sync;
    logic [1:0]           cap_edge;
    logic                 q_up, q_dn;
    logic                 tick_lo, tick_hi;
    logic                 chain;
    logic                 inc_lo, dec_lo, inc_hi, dec_hi;
    logic                 ld_lo, ld_hi;
    logic                 carry_lo, borrow_lo;
    logic                 carry_hi, borrow_hi;

    // Prescaler taps: code n fires once every 2^(DIV_LOG2*n) cycles
    assign tick[0] = 1'b1;
    for (genvar n = 1; n < DIV_CODES; n++) begin : g_tap
        assign tick[n] = &st_q.ps[DIV_LOG2*n-1:0];
    end

    ctmr_sync #(.N(2)) i_cap_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({cap_hi_pin, cap_lo_pin}),
        .sync_o (cap_sync)
    );

    ctmr_sync #(.N(2)) i_enc_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({enc_a, enc_b}),
        .sync_o (enc_sync)
    );

    ctmr_quad i_quad (
        .clk    (clk),
        .rst_n  (rst_n),
        .ph_a   (enc_sync[1]),
        .ph_b   (enc_sync[0]),
        .step_up(q_up),
        .step_dn(q_dn)
    );

    always_comb begin
        tick_lo = 1'b0;
        tick_hi = 1'b0;
        for (int i = 0; i < DIV_CODES; i++) begin
            if (st_q.csel_lo == CSEL_W'(i)) tick_lo = tick[i];
            if (st_q.csel_hi == CSEL_W'(i)) tick_hi = tick[i];
        end
        chain    = (st_q.csel_hi == CSEL_CHAIN);
        cap_edge = cap_sync & ~st_q.cap_prev;

        ld_lo  = wr_en && (reg_addr_e'(wr_addr) == A_CNT_LO);
        ld_hi  = wr_en && (reg_addr_e'(wr_addr) == A_CNT_HI);

        inc_lo = st_q.run_lo && (st_q.phase_lo ? q_up : tick_lo);
        dec_lo = st_q.run_lo && st_q.phase_lo && q_dn;
        inc_hi = st_q.run_hi && (chain ? carry_lo : tick_hi);
        dec_hi = st_q.run_hi && chain && borrow_lo;

        st_d          = st_q;
        st_d.ps       = st_q.ps + 1'b1;
        st_d.cap_prev = cap_sync;
        if (wr_en) begin
            unique case (reg_addr_e'(wr_addr))
                A_CTL_LO: begin
                    st_d.csel_lo  = wr_data[CSEL_W-1:0];
                    st_d.phase_lo = wr_data[CSEL_W];
                end
                A_CTL_HI: st_d.csel_hi = wr_data[CSEL_W-1:0];
                A_RUN: begin
                    st_d.run_lo = wr_data[0];
                    st_d.run_hi = wr_data[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    ctmr_chan #(.W(CNT_W)) i_lo (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (inc_lo),
        .dec     (dec_lo),
        .ld      (ld_lo),
        .ld_val  (wr_data),
        .cap_edge(cap_edge[0]),
        .cnt     (cnt_lo),
        .cap     (cap_lo),
        .carry   (carry_lo),
        .borrow  (borrow_lo)
    );

    ctmr_chan #(.W(CNT_W)) i_hi (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (inc_hi),
        .dec     (dec_hi),
        .ld      (ld_hi),
        .ld_val  (wr_data),
        .cap_edge(cap_edge[1]),
        .cnt     (cnt_hi),
        .cap     (cap_hi),
        .carry   (carry_hi),
        .borrow  (borrow_hi)
    );

    p_stopped_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run_lo && !ld_lo) |=> $stable(cnt_lo));

    p_chain_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chain && st_q.run_hi && carry_lo && !ld_hi) |=>
            (cnt_hi == CNT_W'($past(cnt_hi) + 1'b1)));

    p_chain_borrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chain && st_q.run_hi && borrow_lo && !ld_hi) |=>
            (cnt_hi == CNT_W'($past(cnt_hi) - 1'b1)));

    p_wrap_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (chain && !st_q.run_hi && !ld_hi) |=> $stable(cnt_hi));
endmodule

// File: tb/test_ctmr_top.sv
module test_ctmr_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;
    logic        cap_lo_pin, cap_hi_pin, enc_a, enc_b;
    logic [15:0] cnt_lo, cnt_hi, cap_lo, cap_hi;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    logic [1:0]  ab;
    logic [31:0] pos;

    always #10 clk = ~clk;

    ctmr_top i_ctmr_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cap_lo_pin(cap_lo_pin), .cap_hi_pin(cap_hi_pin),
        .enc_a(enc_a), .enc_b(enc_b), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
        .cap_lo(cap_lo), .cap_hi(cap_hi)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Called just after a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input logic [1:0] which, input int n);
        wr(3'd2, {14'd0, which});
        repeat (n - 1) @(negedge clk);
        wr(3'd2, 16'd0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [1:0] fwd_of(input logic [1:0] s);
        case (s)
            2'b00: fwd_of = 2'b10;
            2'b10: fwd_of = 2'b11;
            2'b11: fwd_of = 2'b01;
            default: fwd_of = 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] back_of(input logic [1:0] s);
        case (s)
            2'b10: back_of = 2'b00;
            2'b11: back_of = 2'b10;
            2'b01: back_of = 2'b11;
            default: back_of = 2'b01;
        endcase
    endfunction

    task automatic enc_set(input logic [1:0] s);
        ab = s; enc_a = s[1]; enc_b = s[0];
        idle(6);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++; n_run++;
                $display("FAIL watchdog: got %0d cycles expected completion", cyc);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        cap_lo_pin = 1'b0; cap_hi_pin = 1'b0; enc_a = 1'b0; enc_b = 1'b0; ab = 2'b00;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 counts", {cnt_hi, cnt_lo}, 32'd0);
        check("R1 captures", {cap_hi, cap_lo}, 32'd0);
        run(2'b11, 8);
        check("R1 selects zero means divide-by-one upper", {16'd0, cnt_hi}, 32'd8);
        check("R1 selects zero means divide-by-one lower", {16'd0, cnt_lo}, 32'd8);

        // R2 presets
        wr(3'd3, 16'h1234); wr(3'd4, 16'hABCD);
        check("R2 preset", {cnt_hi, cnt_lo}, 32'hABCD1234);

        // R3 prescaler rates, lower half
        for (int code = 0; code < 4; code++) begin
            wr(3'd3, 16'd0); wr(3'd0, 16'(code));
            run(2'b01, 10 << (2 * code));
            check($sformatf("R3 lower code %0d", code), {16'd0, cnt_lo}, 32'd10);
        end
        wr(3'd3, 16'd0); wr(3'd0, 16'd5);
        run(2'b01, 50);
        check("R3 unused code holds", {16'd0, cnt_lo}, 32'd0);

        // R4 lower start clear
        wr(3'd0, 16'd0); wr(3'd3, 16'h0042); wr(3'd1, 16'h000F);
        run(2'b10, 20);
        check("R4 lower held while not started", {16'd0, cnt_lo}, 32'h42);

        // R12 upper on its own prescaled enable
        wr(3'd1, 16'd0); wr(3'd4, 16'd100);
        run(2'b10, 10);
        check("R12 upper code 0", {16'd0, cnt_hi}, 32'd110);
        wr(3'd1, 16'd1);
        run(2'b10, 40);
        check("R12 upper code 1", {16'd0, cnt_hi}, 32'd120);

        // R5 chained carry swept across the wrap
        wr(3'd0, 16'd0); wr(3'd1, 16'h000F);
        for (int k = 0; k < 4; k++) begin
            wr(3'd3, 16'hFFFF - 16'(k)); wr(3'd4, 16'h03A1);
            run(2'b11, 5);
            check($sformatf("R5 chained carry k=%0d", k), {cnt_hi, cnt_lo},
                  {16'h03A1, 16'hFFFF - 16'(k)} + 32'd5);
        end

        // R7 wraps dropped when upper start is clear
        wr(3'd3, 16'hFFFE); wr(3'd4, 16'h0007);
        run(2'b01, 5);
        check("R7 upper unchanged", {16'd0, cnt_hi}, 32'h0007);
        check("R7 lower still wrapped", {16'd0, cnt_lo}, 32'h0003);

        // R8 / R6 quadrature walk across the top wrap and back below zero
        wr(3'd0, 16'h0010); wr(3'd3, 16'hFFFD); wr(3'd4, 16'h0010);
        pos = 32'h0010FFFD;
        wr(3'd2, 16'h0003);
        for (int s = 0; s < 6; s++) begin
            enc_set(fwd_of(ab)); pos = pos + 32'd1;
            check($sformatf("R8 forward step %0d", s), {cnt_hi, cnt_lo}, pos);
        end
        // R9 double transition ignored
        enc_set(ab ^ 2'b11);
        check("R9 double change ignored", {cnt_hi, cnt_lo}, pos);
        for (int s = 0; s < 5; s++) begin
            enc_set(back_of(ab)); pos = pos - 32'd1;
            check($sformatf("R8 backward step %0d", s), {cnt_hi, cnt_lo}, pos);
        end
        wr(3'd3, 16'h0002); pos = {pos[31:16], 16'h0002};
        for (int s = 0; s < 5; s++) begin
            enc_set(back_of(ab)); pos = pos - 32'd1;
            check($sformatf("R6 underflow walk %0d", s), {cnt_hi, cnt_lo}, pos);
        end
        wr(3'd2, 16'd0);
        enc_set(fwd_of(ab));
        check("R4 encoder ignored when stopped", {cnt_hi, cnt_lo}, pos);

        // R11 paired capture swept across the wrap cycle
        wr(3'd0, 16'd0);
        for (int k = 0; k < 4; k++) begin
            wr(3'd3, 16'hFFFF - 16'(k)); wr(3'd4, 16'h0055);
            cap_lo_pin = 1'b1; cap_hi_pin = 1'b1;
            run(2'b11, 4);
            cap_lo_pin = 1'b0; cap_hi_pin = 1'b0;
            idle(4);
            check($sformatf("R11 coherent snapshot k=%0d", k), {cap_hi, cap_lo},
                  {16'h0055, 16'hFFFF - 16'(k)} + 32'd1);
        end

        // R10 single-pin capture
        wr(3'd3, 16'h1111); wr(3'd4, 16'h2222);
        cap_lo_pin = 1'b1;
        idle(5);
        cap_lo_pin = 1'b0;
        idle(3);
        check("R10 lower capture", {16'd0, cap_lo}, 32'h1111);
        check("R10 upper capture unchanged", {16'd0, cap_hi}, 32'h0055);
        cap_hi_pin = 1'b1;
        idle(5);
        check("R10 upper capture", {16'd0, cap_hi}, 32'h2222);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule